// File: doc/BRIEF.md
# Shared LFSR Random Generator and CRC16 Engine

This block holds one 16-bit shift register that serves two jobs. As a pseudo-random source it is stepped forward in bursts of 13 shift steps. Each burst is built as a single unrolled update, so it completes in one clock. As a CRC16 engine it takes one data byte per write and folds that byte into the register, most significant bit first, in a single cycle.

Software sees the register as a low byte and a high byte. A write to the low byte shifts a fresh byte into the register from the bottom, so two such writes load a full seed. A write to the high byte feeds that byte through the CRC. A 2-bit mode field sets how the random side advances. It can advance on each high-byte read, step once and clear itself, or stay stopped.

Top module: `lfsr_crc_core`

## Requirements
- R1: After synchronous reset the register reads 0x0000 on both byte outputs and the mode field reads 00.
- R2: `lfsr_lo` always shows register bits 7:0 and `lfsr_hi` shows bits 15:8, with no extra cycle of delay after the register changes.
- R3: A low-byte write moves the old bits 7:0 into bits 15:8 and places the written byte in bits 7:0 at the same clock edge.
- R4: A high-byte write runs eight CRC steps with polynomial x^16+x^15+x^2+1 (mask 0x8005), starting from the current register and taking data bit 7 first. In each step the feedback is bit 15 XOR the data bit, the register shifts left, and 0x8005 is XORed in when the feedback is 1. With the register seeded to 0x0000, the ASCII bytes "123456789" give 0xFEE8.
- R5: In mode 00, asserting `hi_rd` advances the register by 13 steps of the same shift with a data bit of 0.
- R6: Writing mode 01 makes the register advance by 13 steps on the next clock edge. At that same edge the mode field returns to 00, unless a new mode is written in that cycle.
- R7: In mode 11, `hi_rd` has no effect on the register, while low-byte and high-byte writes still update it.
- R8: Mode 10 is reserved and behaves like mode 11 for advancing: `hi_rd` does not move the register.
- R9: When several updates fall in one cycle, a low-byte write wins over a high-byte write, and a high-byte write wins over any random advance.
- R10: An all-zero register stays all-zero under random advances. It is not forced out of that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_we | input | 1 | Low-byte write strobe (seed shift-in) |
| seed_data | input | 8 | Byte written to the low byte |
| crc_we | input | 1 | High-byte write strobe (CRC update) |
| crc_data | input | 8 | Byte folded into the CRC |
| hi_rd | input | 1 | High-byte read strobe; advances the generator in mode 00 |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 2 | Mode value: 00 run, 01 step once, 10 reserved, 11 stop |
| mode_q | output | 2 | Current mode field |
| lfsr_lo | output | 8 | Register bits 7:0 |
| lfsr_hi | output | 8 | Register bits 15:8 |

## Verification
The hardest case to reach from the ports is a cycle where updates collide: a seed write, a CRC write and an advance on the same edge. A related case is a mode-01 step that coincides with a new mode write. Directed cycles assert these strobes together on purpose. A long stretch of seeded random stimulus then raises each strobe independently at rates high enough that collisions happen often. The CRC path is also pinned by a known check value, so an error shared by the bench model and the design cannot hide.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;

    parameter int          LFSR_W = 16;
    parameter int          BYTE_W = 8;
    parameter logic [15:0] POLY   = 16'h8005;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_ONCE = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_HALT = 2'b11
    } gen_mode_e;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_SEED,
        SRC_CRC,
        SRC_ADV
    } upd_src_e;

    // One serial step: feedback is the top bit XOR the incoming data bit.
    function automatic logic [LFSR_W-1:0] poly_step(input logic [LFSR_W-1:0] s,
                                                    input logic din);
        logic fb;
        fb = s[LFSR_W-1] ^ din;
        return {s[LFSR_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

endpackage

// File: rtl/lfsr_adv_unroll.sv
module lfsr_adv_unroll
    import lfsr_crc_pkg::*;
#(
    parameter int STEPS = 13
) (
    input  logic [LFSR_W-1:0] state_in,
    output logic [LFSR_W-1:0] state_out
);
    logic [LFSR_W-1:0] chain [STEPS+1];

    assign chain[0] = state_in;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign chain[g+1] = poly_step(chain[g], 1'b0);
    end

    assign state_out = chain[STEPS];
endmodule

// File: rtl/crc_byte_unit.sv
module crc_byte_unit
    import lfsr_crc_pkg::*;
(
    input  logic [LFSR_W-1:0] state_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [LFSR_W-1:0] state_out
);
    logic [LFSR_W-1:0] chain [BYTE_W+1];

    assign chain[0] = state_in;

    // Most significant data bit enters first.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign chain[g+1] = poly_step(chain[g], data_in[BYTE_W-1-g]);
    end

    assign state_out = chain[BYTE_W];
endmodule

// File: rtl/gen_mode_ctrl.sv
module gen_mode_ctrl
    import lfsr_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    input  logic       hi_rd,
    output gen_mode_e  mode,
    output logic       adv_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RUN;
        end else if (mode_we) begin
            mode <= gen_mode_e'(mode_wdata);
        end else if (mode == MODE_ONCE) begin
            mode <= MODE_RUN;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_RUN:  adv_req = hi_rd;
            MODE_ONCE: adv_req = 1'b1;
            default:   adv_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/lfsr_crc_core.sv
module lfsr_crc_core
    import lfsr_crc_pkg::*;
#(
    parameter int ADV_STEPS = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_we,
    input  logic [BYTE_W-1:0] seed_data,
    input  logic              crc_we,
    input  logic [BYTE_W-1:0] crc_data,
    input  logic              hi_rd,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_q,
    output logic [BYTE_W-1:0] lfsr_lo,
    output logic [BYTE_W-1:0] lfsr_hi
);
    localparam int HI_W = LFSR_W - BYTE_W;

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] adv_next;
    logic [LFSR_W-1:0] crc_next;
    logic [LFSR_W-1:0] seed_next;
    logic [LFSR_W-1:0] state_d;
    gen_mode_e         mode;
    logic              adv_req;
    upd_src_e          src;

    gen_mode_ctrl u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .hi_rd      (hi_rd),
        .mode       (mode),
        .adv_req    (adv_req)
    );

    lfsr_adv_unroll #(.STEPS(ADV_STEPS)) u_adv (
        .state_in  (state_q),
        .state_out (adv_next)
    );

    crc_byte_unit u_crc (
        .state_in  (state_q),
        .data_in   (crc_data),
        .state_out (crc_next)
    );

    assign seed_next = {state_q[HI_W-1:0], seed_data};

    always_comb begin
        if (seed_we)      src = SRC_SEED;
        else if (crc_we)  src = SRC_CRC;
        else if (adv_req) src = SRC_ADV;
        else              src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_SEED: state_d = seed_next;
            SRC_CRC:  state_d = crc_next;
            SRC_ADV:  state_d = adv_next;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign mode_q  = mode;
    assign lfsr_lo = state_q[BYTE_W-1:0];
    assign lfsr_hi = state_q[LFSR_W-1:BYTE_W];
endmodule

// File: rtl/lfsr_crc_checker.sv
module lfsr_crc_checker (
    input logic       clk,
    input logic       rst,
    input logic       seed_we,
    input logic [7:0] seed_data,
    input logic       crc_we,
    input logic       mode_we,
    input logic [1:0] mode_q,
    input logic [7:0] lfsr_lo,
    input logic [7:0] lfsr_hi
);
    // R3
    seed_shift_chk: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> (lfsr_lo == $past(seed_data) && lfsr_hi == $past(lfsr_lo)));

    // R6
    once_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b01 && !mode_we) |=> (mode_q == 2'b00));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b11 && !seed_we && !crc_we) |=> $stable({lfsr_hi, lfsr_lo}));

    // R8
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b10 && !seed_we && !crc_we) |=> $stable({lfsr_hi, lfsr_lo}));

    // R10
    zero_lock_chk: assert property (@(posedge clk) disable iff (rst)
        ({lfsr_hi, lfsr_lo} == 16'h0000 && !seed_we && !crc_we) |=> ({lfsr_hi, lfsr_lo} == 16'h0000));
endmodule

bind lfsr_crc_core lfsr_crc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_we   (seed_we),
    .seed_data (seed_data),
    .crc_we    (crc_we),
    .mode_we   (mode_we),
    .mode_q    (mode_q),
    .lfsr_lo   (lfsr_lo),
    .lfsr_hi   (lfsr_hi)
);

// File: tb/lfsr_crc_core_tb_top.sv
`timescale 1ns/1ps
module lfsr_crc_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       seed_we = 1'b0;
    logic [7:0] seed_data = '0;
    logic       crc_we = 1'b0;
    logic [7:0] crc_data = '0;
    logic       hi_rd = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = '0;
    logic [1:0] mode_q;
    logic [7:0] lfsr_lo;
    logic [7:0] lfsr_hi;

    int errors = 0;
    int checks = 0;
    logic [15:0] m_reg = '0;
    logic [1:0]  m_mode = '0;

    always #5 clk = ~clk;

    lfsr_crc_core dut_i (
        .clk(clk), .rst(rst),
        .seed_we(seed_we), .seed_data(seed_data),
        .crc_we(crc_we), .crc_data(crc_data),
        .hi_rd(hi_rd),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .lfsr_lo(lfsr_lo), .lfsr_hi(lfsr_hi)
    );

    function automatic logic [15:0] ref_adv(input logic [15:0] s);
        logic [15:0] r = s;
        for (int i = 0; i < 13; i++) begin
            if (r[15]) r = (r << 1) ^ 16'h8005;
            else       r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] s, input logic [7:0] d);
        logic [15:0] r = s;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ d[i];
            r = r << 1;
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic apply(input logic sw, input logic [7:0] sd, input logic cw, input logic [7:0] cd,
                         input logic rd, input logic mw, input logic [1:0] md, input string tag);
        logic adv;
        seed_we = sw; seed_data = sd; crc_we = cw; crc_data = cd;
        hi_rd = rd; mode_we = mw; mode_wdata = md;
        @(posedge clk);
        adv = (m_mode == 2'b01) || (m_mode == 2'b00 && rd);
        if (sw)       m_reg = {m_reg[7:0], sd};
        else if (cw)  m_reg = ref_crc(m_reg, cd);
        else if (adv) m_reg = ref_adv(m_reg);
        if (mw)                     m_mode = md;
        else if (m_mode == 2'b01)   m_mode = 2'b00;
        @(negedge clk);
        seed_we = 1'b0; crc_we = 1'b0; hi_rd = 1'b0; mode_we = 1'b0;
        chk(tag, {lfsr_hi, lfsr_lo}, m_reg);
        chk(tag, {14'd0, mode_q}, {14'd0, m_mode});
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] msg [9];
        msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", {lfsr_hi, lfsr_lo}, 16'h0000);
        chk("R1", {14'd0, mode_q}, 16'h0000);
        // R10 zero state held under an advance
        apply(0, 0, 0, 0, 1, 0, 0, "R10");
        chk("R10", {lfsr_hi, lfsr_lo}, 16'h0000);
        // R3 and R2 two-byte seed
        apply(1, 8'hAB, 0, 0, 0, 0, 0, "R3");
        apply(1, 8'hCD, 0, 0, 0, 0, 0, "R3");
        chk("R2", {8'd0, lfsr_hi}, 16'h00AB);
        chk("R2", {8'd0, lfsr_lo}, 16'h00CD);
        // R5 read-triggered advance
        apply(0, 0, 0, 0, 1, 0, 0, "R5");
        chk("R5", {lfsr_hi, lfsr_lo}, ref_adv(16'hABCD));
        // R6 single step and self-clear
        apply(0, 0, 0, 0, 0, 1, 2'b01, "R6");
        apply(0, 0, 0, 0, 0, 0, 0, "R6");
        chk("R6", {14'd0, mode_q}, 16'h0000);
        // R6 step while a new mode is written the same cycle
        apply(0, 0, 0, 0, 0, 1, 2'b01, "R6");
        apply(0, 0, 0, 0, 0, 1, 2'b11, "R6");
        // R7 stopped: reads ignored, writes still act
        apply(0, 0, 0, 0, 1, 0, 0, "R7");
        apply(1, 8'h5A, 0, 0, 0, 0, 0, "R7");
        apply(0, 0, 1, 8'hC3, 1, 0, 0, "R7");
        // R8 reserved mode does not advance
        apply(0, 0, 0, 0, 0, 1, 2'b10, "R8");
        apply(0, 0, 0, 0, 1, 0, 0, "R8");
        // R4 known check value
        apply(0, 0, 0, 0, 0, 1, 2'b00, "R4");
        apply(1, 8'h00, 0, 0, 0, 0, 0, "R4");
        apply(1, 8'h00, 0, 0, 0, 0, 0, "R4");
        foreach (msg[i]) apply(0, 0, 1, msg[i], 0, 0, 0, "R4");
        chk("R4", {lfsr_hi, lfsr_lo}, 16'hFEE8);
        // R9 priority
        apply(1, 8'h77, 1, 8'h99, 1, 0, 0, "R9");
        apply(0, 0, 1, 8'h12, 1, 0, 0, "R9");
        apply(0, 0, 1, 8'h34, 0, 1, 2'b01, "R9");
        apply(1, 8'h56, 1, 8'h78, 0, 0, 0, "R9");
        // Seeded random mix
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic sw, cw, rd, mw;
            string tag;
            sw = ($urandom % 100) < 15;
            cw = ($urandom % 100) < 20;
            rd = ($urandom % 100) < 45;
            mw = ($urandom % 100) < 8;
            tag = sw ? "R3" : (cw ? "R4" : "R5");
            apply(sw, 8'($urandom), cw, 8'($urandom), rd, mw, 2'($urandom), tag);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule